// File: doc/BRIEF.md
# Stopwatch and Timebase Unit

This unit counts a free-running 8-bit stopwatch value and produces two periodic timebase flags from a single-cycle tick pulse. The tick arrives at 128 Hz from an uncompensated reference, so the timebase and stopwatch activity need not line up with any trimmed time-of-day logic elsewhere on the chip. Software drives the unit through a small register port. Address 0 is a control register and address 1 returns the stopwatch count.

The control register has four bits. A master run bit gates every tick; clearing it freezes the unit without changing any stored value. A stopwatch enable bit lets the counter advance or hold it. A write-only zero bit resets the count. A rate bit shortens both timebase periods by a factor of four. Each timebase flag stays set until its acknowledge line is pulsed.

Top module: `stopwatch_timebase`

## Requirements
- R1: After reset, the control register reads 0x00, the stopwatch count reads 0x00 and both timebase flags are 0.
- R2: On a read of address 0, bit 0 returns the run bit, bit 1 the stopwatch enable and bit 3 the rate select. Bit 2 and bits 7:4 read 0. On a read of address 1, the stopwatch count is returned. Read data is combinational from `addr_i`. A write to address 1 changes nothing.
- R3: While run and stopwatch enable are both 1, each tick raises the count by one on the next clock edge, and 0xFF wraps to 0x00.
- R4: While the stopwatch enable is 0, the count holds its value.
- R5: A write to address 0 with bit 2 set makes the count 0x00 on the next edge. This happens whatever the enables are and even if a tick arrives in the same cycle. The other written bits load as usual, and the timebase dividers and flags are not affected.
- R6: While run is 0, ticks are ignored: the count, both divider states and both flags stay as they are. The acknowledge inputs still clear the flags.
- R7: Timebase 1 sets flag bit 0 on every 64th accepted tick when the rate bit is 0, and on every 16th when it is 1.
- R8: Timebase 2 sets flag bit 1 on every 32nd accepted tick when the rate bit is 0, and on every 8th when it is 1.
- R9: A set flag stays 1 until its acknowledge bit is high at a clock edge. If a set and an acknowledge land in the same cycle, the flag ends up 1.
- R10: A control write that changes the rate bit restarts both dividers from zero, and a tick in that cycle is not counted. A control write that keeps the rate bit leaves the dividers running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 128 Hz tick pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address: 0 control, 1 stopwatch |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| tb_ack_i | input | 2 | Flag acknowledge, one bit per timebase |
| tb_flag_o | output | 2 | Timebase flags: bit 0 timebase 1, bit 1 timebase 2 |

## Verification
The assertions assume that `tick_i` is a clean single-cycle pulse, that the write strobe and address are stable around the clock edge, and that a change of the rate bit only ever arrives through a control write. The divider-range check depends on that last point. The bench drives every input at the falling edge, so the inputs are steady at each rising edge. It produces ticks, acknowledges and writes at random, and the random writes also change the rate bit in the middle of a period. Directed cases then hit the set/acknowledge collision, a zero request landing on a tick, the 0xFF wrap and a long run with the unit frozen.

// File: rtl/swtb_pkg.sv
package swtb_pkg;
  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned CHR_BIT  = 1;
  localparam int unsigned CLR_BIT  = 2;
  localparam int unsigned FAST_BIT = 3;

  localparam logic ADDR_CTRL   = 1'b0;
  localparam logic ADDR_CHRONO = 1'b1;

  typedef struct packed {
    logic fast;
    logic chr_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/swtb_ctrl_reg.sv
module swtb_ctrl_reg
  import swtb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic              clr_o,
  output logic              restart_o
);
  ctrl_t ctrl_q;
  logic  ctrl_wr;
  logic  unused_wdata;

  assign ctrl_wr      = wr_en_i && (addr_i == ADDR_CTRL);
  assign clr_o        = ctrl_wr && wdata_i[CLR_BIT];
  assign restart_o    = ctrl_wr && (wdata_i[FAST_BIT] != ctrl_q.fast);
  assign unused_wdata = ^wdata_i[DATA_W-1:FAST_BIT+1];
  assign ctrl_o       = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.run    <= wdata_i[RUN_BIT];
      ctrl_q.chr_en <= wdata_i[CHR_BIT];
      ctrl_q.fast   <= wdata_i[FAST_BIT];
    end
  end

  // R2
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(ctrl_q));
  // R10
  restart_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> ctrl_q.fast != $past(ctrl_q.fast));
endmodule

// File: rtl/swtb_chrono.sv
module swtb_chrono #(
  parameter int CHR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clr_i,
  output logic [CHR_W-1:0] count_o
);
  logic [CHR_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (clr_i)  count_q <= '0;
    else if (step_i) count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;

  // R5
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_q == '0);
  // R3
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clr_i |=> count_q == CHR_W'($past(count_q) + 1'b1));
  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !clr_i |=> $stable(count_q));
endmodule

// File: rtl/swtb_timebase.sv
module swtb_timebase #(
  parameter int SLOW_DIV = 64,
  parameter int SPEEDUP  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fast_i,
  input  logic restart_i,
  input  logic ack_i,
  output logic flag_o
);
  localparam int FAST_DIV = SLOW_DIV / SPEEDUP;
  localparam int CNT_W    = $clog2(SLOW_DIV);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             wrap;
  logic             flag_q;

  assign last = fast_i ? CNT_W'(FAST_DIV - 1) : CNT_W'(SLOW_DIV - 1);
  assign wrap = tick_i && !restart_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  // set beats acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (wrap)  flag_q <= 1'b1;
    else if (ack_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R10
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
  // R7
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !ack_i |=> flag_q);
  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> flag_q);
  // R6
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !restart_i |=> $stable(cnt_q));
endmodule

// File: rtl/stopwatch_timebase.sv
module stopwatch_timebase
  import swtb_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CHR_W    = 8,
  parameter int TB1_SLOW = 64,
  parameter int TB2_SLOW = 32,
  parameter int SPEEDUP  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [1:0]        tb_ack_i,
  output logic [1:0]        tb_flag_o
);
  localparam int NUM_TB = 2;

  ctrl_t            ctrl;
  logic             clr;
  logic             restart;
  logic             tick_en;
  logic [CHR_W-1:0] chr_cnt;

  assign tick_en = tick_i && ctrl.run;

  swtb_ctrl_reg #(.DATA_W(DATA_W)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .ctrl_o    (ctrl),
    .clr_o     (clr),
    .restart_o (restart)
  );

  swtb_chrono #(.CHR_W(CHR_W)) i_chrono (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (tick_en && ctrl.chr_en),
    .clr_i   (clr),
    .count_o (chr_cnt)
  );

  for (genvar g = 0; g < NUM_TB; g++) begin : g_tb
    localparam int SLOW = (g == 0) ? TB1_SLOW : TB2_SLOW;
    swtb_timebase #(.SLOW_DIV(SLOW), .SPEEDUP(SPEEDUP)) i_tb (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_en),
      .fast_i    (ctrl.fast),
      .restart_i (restart),
      .ack_i     (tb_ack_i[g]),
      .flag_o    (tb_flag_o[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) begin
      rdata_o[RUN_BIT]  = ctrl.run;
      rdata_o[CHR_BIT]  = ctrl.chr_en;
      rdata_o[FAST_BIT] = ctrl.fast;
    end else begin
      rdata_o[CHR_W-1:0] = chr_cnt;
    end
  end

  // R6
  frozen_chrono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.run && !clr |=> $stable(chr_cnt));
  // R6
  frozen_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.run && (tb_ack_i == 2'b00) |=> $stable(tb_flag_o));
endmodule

// File: tb/test_stopwatch_timebase.sv
module test_stopwatch_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [1:0] tb_ack_i = '0;
  logic [1:0] tb_flag_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic       run_m = 0, chr_en_m = 0, fast_m = 0;
  logic [7:0] chr_m = '0;
  int         cnt_m [2] = '{0, 0};
  logic [1:0] flag_m = '0;

  stopwatch_timebase i_stopwatch_timebase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .tb_ack_i (tb_ack_i),
    .tb_flag_o(tb_flag_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic int period(int g, logic fast);
    int base = (g == 0) ? 64 : 32;
    return fast ? base / 4 : base;
  endfunction

  function automatic logic [7:0] ctrl_exp();
    return {4'b0, fast_m, 1'b0, chr_en_m, run_m};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_step(logic tk, logic wr, logic ad, logic [7:0] wd, logic [1:0] ack);
    logic ctrl_wr = wr && (ad == 1'b0);
    logic acc     = tk && run_m;
    logic rst_div = ctrl_wr && (wd[3] != fast_m);
    for (int g = 0; g < 2; g++) begin
      logic set = 0;
      if (rst_div) cnt_m[g] = 0;
      else if (acc) begin
        if (cnt_m[g] == period(g, fast_m) - 1) begin
          cnt_m[g] = 0;
          set = 1;
        end else cnt_m[g]++;
      end
      if (set) flag_m[g] = 1'b1;
      else if (ack[g]) flag_m[g] = 1'b0;
    end
    if (ctrl_wr && wd[2]) chr_m = '0;
    else if (acc && chr_en_m) chr_m = chr_m + 8'd1;
    if (ctrl_wr) begin
      run_m    = wd[0];
      chr_en_m = wd[1];
      fast_m   = wd[3];
    end
  endtask

  task automatic read_reg(logic ad, output logic [7:0] val);
    addr_i = ad;
    #1;
    val = rdata_o;
  endtask

  task automatic check_all();
    logic [7:0] v;
    read_reg(1'b0, v);
    chk("R2", v, ctrl_exp());
    read_reg(1'b1, v);
    chk("R3", v, chr_m);
    chk("R7", {7'b0, tb_flag_o[0]}, {7'b0, flag_m[0]});
    chk("R8", {7'b0, tb_flag_o[1]}, {7'b0, flag_m[1]});
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(logic tk, logic wr, logic ad, logic [7:0] wd, logic [1:0] ack);
    tick_i = tk; wr_en_i = wr; addr_i = ad; wdata_i = wd; tb_ack_i = ack;
    model_step(tk, wr, ad, wd, ack);
    @(posedge clk_i);
    @(negedge clk_i);
    tick_i = 0; wr_en_i = 0; tb_ack_i = '0;
    check_all();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00, 2'b00);
  endtask

  task automatic wr_ctrl(logic [7:0] wd);
    cyc(1'b0, 1'b1, 1'b0, wd, 2'b00);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd5171));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    read_reg(1'b0, v); chk("R1", v, 8'h00);
    read_reg(1'b1, v); chk("R1", v, 8'h00);
    chk("R1", {6'b0, tb_flag_o}, 8'h00);

    // R3 counting, R8 first timebase 2 period
    wr_ctrl(8'h03);
    ticks(31);
    chk("R8", {7'b0, tb_flag_o[1]}, 8'h00);
    ticks(1);
    chk("R8", {7'b0, tb_flag_o[1]}, 8'h01);
    read_reg(1'b1, v); chk("R3", v, 8'd32);
    cyc(1'b0, 1'b0, 1'b0, 8'h00, 2'b00);
    chk("R9", {7'b0, tb_flag_o[1]}, 8'h01);

    // R9 set wins over acknowledge on tick 64
    ticks(31);
    cyc(1'b1, 1'b0, 1'b0, 8'h00, 2'b01);
    chk("R9", {7'b0, tb_flag_o[0]}, 8'h01);
    cyc(1'b0, 1'b0, 1'b0, 8'h00, 2'b11);
    chk("R9", {6'b0, tb_flag_o}, 8'h00);

    // R4 hold with stopwatch disabled
    wr_ctrl(8'h01);
    read_reg(1'b1, v);
    ticks(5);
    begin
      logic [7:0] v2;
      read_reg(1'b1, v2);
      chk("R4", v2, v);
    end

    // R6 frozen: ticks ignored, acknowledge still works
    ticks(27);
    wr_ctrl(8'h02);
    read_reg(1'b1, v);
    ticks(100);
    begin
      logic [7:0] v2;
      read_reg(1'b1, v2);
      chk("R6", v2, v);
    end
    chk("R6", {6'b0, tb_flag_o}, {6'b0, flag_m});
    wr_ctrl(8'h03);

    // R5 zero request on a tick; control bits load, bit 2 reads 0
    cyc(1'b1, 1'b1, 1'b0, 8'h07, 2'b00);
    read_reg(1'b1, v); chk("R5", v, 8'h00);
    read_reg(1'b0, v); chk("R5", v, 8'h03);
    // R2 write to address 1 is ignored
    cyc(1'b0, 1'b1, 1'b1, 8'h5A, 2'b00);
    read_reg(1'b1, v); chk("R2", v, 8'h00);

    // R3 wrap 0xFF -> 0x00
    ticks(255);
    read_reg(1'b1, v); chk("R3", v, 8'hFF);
    ticks(1);
    read_reg(1'b1, v); chk("R3", v, 8'h00);

    // R10 rate change restarts dividers; same rate does not
    cyc(1'b0, 1'b0, 1'b0, 8'h00, 2'b11);
    ticks(5);
    cyc(1'b1, 1'b1, 1'b0, 8'h0B, 2'b00);
    ticks(7);
    chk("R10", {6'b0, tb_flag_o}, 8'h00);
    wr_ctrl(8'h0B);
    ticks(1);
    chk("R10", {7'b0, tb_flag_o[1]}, 8'h01);
    ticks(8);
    chk("R7", {7'b0, tb_flag_o[0]}, 8'h01);

    // constrained random phase
    for (int i = 0; i < 3000; i++) begin
      logic       tk  = ($urandom % 2) == 0;
      logic [1:0] ack = {($urandom % 8) == 0, ($urandom % 8) == 0};
      logic       wr  = ($urandom % 40) == 0;
      logic       ad  = ($urandom % 4) == 0;
      logic [7:0] wd  = 8'($urandom);
      if (wr && !ad) wd[0] = ($urandom % 4) != 0;
      cyc(tk, wr, ad, wd, ack);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule